// File: doc/BRIEF.md
# USB Start-of-Frame Tracker

This block follows the start-of-frame tokens that a USB host sends at the start of every frame. An upstream packet decoder supplies four things: a one-cycle strobe when the start-of-frame packet identifier is recognised, the 11-bit frame field of the token, a one-cycle strobe at end of packet, and a flag that reports a CRC5 failure on the token. From these the block keeps the frame number of the most recent good token and two status flags, one for a good token and one for a bad token. It also raises a one-cycle interrupt pulse as soon as the identifier is seen. A 32-bit status word presents all of this to a register read path.

A two-state machine drives the block. In `ST_IDLE` no packet is open, and an end-of-packet strobe changes nothing. The transition `PID_SEEN` (identifier strobe) always leads to `ST_ARMED`. It clears both flags and fires the interrupt on the next cycle. In `ST_ARMED` the transition `EOP_DONE` (end-of-packet strobe with no identifier strobe in the same cycle) returns to `ST_IDLE`. On that transition the block either loads the frame number and sets the OK flag, or, when the token is bad, keeps the frame number and sets the error flag. A new `PID_SEEN` while the machine is in `ST_ARMED` starts the packet again and the machine stays armed.

Top module: `sof_frame_tracker`

## Requirements
- R1: After reset the frame number is 0, both flags are clear, the interrupt is low and the status word is 0.
- R2: An identifier strobe in cycle N drives the interrupt high in cycle N+1 for exactly one cycle. It fires whether or not an end of packet follows.
- R3: An identifier strobe clears the OK flag and the error flag from the next cycle on.
- R4: An end-of-packet strobe in the armed state with the error input low loads the frame field into the frame number and sets the OK flag on the next cycle.
- R5: An end-of-packet strobe in the armed state with the error input high sets the error flag and leaves the frame number unchanged.
- R6: The OK flag and the error flag are never high together.
- R7: An end-of-packet strobe with no open packet changes neither the frame number nor the flags. This covers a second end of packet after a packet has already completed.
- R8: When the identifier and end-of-packet strobes come in the same cycle, the cycle counts as an identifier only. The flags clear, the frame number is held, and the next end of packet completes the packet.
- R9: The status word carries the frame number in bits 10..0, the error flag in bit 16 and the OK flag in bit 17. All other bits are 0.
- R10: Between an identifier and its end of packet, both flags stay clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof_pid_stb | input | 1 | Start-of-frame identifier seen |
| eop_stb | input | 1 | End of packet |
| tok_err | input | 1 | Token CRC5 error, valid with `eop_stb` |
| frame_field | input | 11 | Frame field of the token |
| frame_num | output | 11 | Frame number of the last good token |
| frame_ok | output | 1 | Last token was received intact |
| frame_err | output | 1 | Last token was received with an error |
| sof_irq | output | 1 | One-cycle start-of-frame interrupt |
| status_word | output | 32 | Read view of the frame number and the flags |

## Verification
The bench builds the block with its default parameters: an 11-bit frame, a 32-bit word, and the flag positions 16 and 17. With these the all-ones frame value 0x7FF is reachable, and the bench checks that no frame bit spills into the gap below the flags. The walked vector table runs through every transition of the machine: an orphan end of packet in `ST_IDLE`, an identifier that arrives again while armed, and an identifier together with an end of packet in the same cycle. It also shows that a bad token freezes the frame number after a good one.

// File: rtl/sof_trk_pkg.sv
package sof_trk_pkg;
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } sof_state_e;
endpackage

// File: rtl/sof_trk_fsm.sv
module sof_trk_fsm
    import sof_trk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pid_stb,
    input  logic eop_stb,
    output logic clear_flags,
    output logic capture,
    output logic irq
);
    sof_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state: PID_SEEN has priority over EOP_DONE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pid_stb) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (pid_stb)      state_d = ST_ARMED;
                else if (eop_stb) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        clear_flags = pid_stb;
        capture     = 1'b0;
        unique case (state_q)
            ST_IDLE:  capture = 1'b0;
            ST_ARMED: capture = eop_stb && !pid_stb;
            default:  capture = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= pid_stb;
    end
endmodule

// File: rtl/sof_trk_status.sv
module sof_trk_status #(
    parameter int FRAME_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_flags,
    input  logic               capture,
    input  logic               tok_err,
    input  logic [FRAME_W-1:0] frame_field,
    output logic [FRAME_W-1:0] frame_num,
    output logic               frame_ok,
    output logic               frame_err
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_num <= '0;
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
        end else if (clear_flags) begin
            frame_ok  <= 1'b0;
            frame_err <= 1'b0;
        end else if (capture) begin
            if (tok_err) begin
                frame_err <= 1'b1;
                frame_ok  <= 1'b0;
            end else begin
                frame_num <= frame_field;
                frame_ok  <= 1'b1;
                frame_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sof_trk_readmap.sv
module sof_trk_readmap #(
    parameter int FRAME_W = 11,
    parameter int WORD_W  = 32,
    parameter int ERR_POS = 16,
    parameter int OK_POS  = 17
) (
    input  logic [FRAME_W-1:0] frame_num,
    input  logic               frame_ok,
    input  logic               frame_err,
    output logic [WORD_W-1:0]  word
);
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        if (i < FRAME_W) begin : g_frame
            assign word[i] = frame_num[i];
        end else if (i == ERR_POS) begin : g_err
            assign word[i] = frame_err;
        end else if (i == OK_POS) begin : g_ok
            assign word[i] = frame_ok;
        end else begin : g_zero
            assign word[i] = 1'b0;
        end
    end
endmodule

// File: rtl/sof_frame_tracker.sv
module sof_frame_tracker #(
    parameter int FRAME_W = 11,
    parameter int WORD_W  = 32,
    parameter int ERR_POS = 16,
    parameter int OK_POS  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sof_pid_stb,
    input  logic               eop_stb,
    input  logic               tok_err,
    input  logic [FRAME_W-1:0] frame_field,
    output logic [FRAME_W-1:0] frame_num,
    output logic               frame_ok,
    output logic               frame_err,
    output logic               sof_irq,
    output logic [WORD_W-1:0]  status_word
);
    logic clear_flags;
    logic capture;

    sof_trk_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .pid_stb     (sof_pid_stb),
        .eop_stb     (eop_stb),
        .clear_flags (clear_flags),
        .capture     (capture),
        .irq         (sof_irq)
    );

    sof_trk_status #(.FRAME_W(FRAME_W)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_flags (clear_flags),
        .capture     (capture),
        .tok_err     (tok_err),
        .frame_field (frame_field),
        .frame_num   (frame_num),
        .frame_ok    (frame_ok),
        .frame_err   (frame_err)
    );

    sof_trk_readmap #(
        .FRAME_W (FRAME_W),
        .WORD_W  (WORD_W),
        .ERR_POS (ERR_POS),
        .OK_POS  (OK_POS)
    ) u_readmap (
        .frame_num (frame_num),
        .frame_ok  (frame_ok),
        .frame_err (frame_err),
        .word      (status_word)
    );
endmodule

// File: rtl/sof_frame_tracker_chk.sv
module sof_frame_tracker_chk #(
    parameter int FRAME_W = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sof_pid_stb,
    input logic [FRAME_W-1:0] frame_field,
    input logic [FRAME_W-1:0] frame_num,
    input logic               frame_ok,
    input logic               frame_err,
    input logic               sof_irq
);
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(frame_ok && frame_err)); // R6
    AST_IRQ_AFTER_PID: assert property (@(posedge clk) disable iff (!rst_n) sof_pid_stb |=> sof_irq); // R2
    AST_IRQ_ONLY_PID: assert property (@(posedge clk) disable iff (!rst_n) !sof_pid_stb |=> !sof_irq); // R2
    AST_PID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) sof_pid_stb |=> (!frame_ok && !frame_err)); // R3
    AST_ERR_HOLDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_err) |-> $stable(frame_num)); // R5
    AST_OK_LOADS_FRAME: assert property (@(posedge clk) disable iff (!rst_n) $rose(frame_ok) |-> frame_num == $past(frame_field)); // R4
endmodule

bind sof_frame_tracker sof_frame_tracker_chk #(.FRAME_W(FRAME_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sof_pid_stb (sof_pid_stb),
    .frame_field (frame_field),
    .frame_num   (frame_num),
    .frame_ok    (frame_ok),
    .frame_err   (frame_err),
    .sof_irq     (sof_irq)
);

// File: tb/sof_frame_tracker_test.sv
module sof_frame_tracker_test;
    localparam int NV = 14;
    // {pid, eop, err, field[10:0], exp_frame[10:0], exp_ok, exp_err, exp_irq}
    localparam logic [27:0] VEC [NV] = '{
        {1'b1, 1'b0, 1'b0, 11'h000, 11'h000, 1'b0, 1'b0, 1'b1}, // R2 pid
        {1'b0, 1'b0, 1'b0, 11'h000, 11'h000, 1'b0, 1'b0, 1'b0}, // R10 armed, flags clear
        {1'b0, 1'b1, 1'b0, 11'h155, 11'h155, 1'b1, 1'b0, 1'b0}, // R4 good token
        {1'b0, 1'b1, 1'b0, 11'h7FF, 11'h155, 1'b1, 1'b0, 1'b0}, // R7 orphan eop
        {1'b1, 1'b0, 1'b0, 11'h000, 11'h155, 1'b0, 1'b0, 1'b1}, // R3 pid clears
        {1'b0, 1'b1, 1'b1, 11'h0AA, 11'h155, 1'b0, 1'b1, 1'b0}, // R5 bad token
        {1'b1, 1'b1, 1'b0, 11'h300, 11'h155, 1'b0, 1'b0, 1'b1}, // R8 pid+eop together
        {1'b0, 1'b1, 1'b0, 11'h300, 11'h300, 1'b1, 1'b0, 1'b0}, // R8 next eop completes
        {1'b1, 1'b0, 1'b0, 11'h000, 11'h300, 1'b0, 1'b0, 1'b1}, // R2
        {1'b0, 1'b0, 1'b0, 11'h000, 11'h300, 1'b0, 1'b0, 1'b0}, // R10
        {1'b1, 1'b0, 1'b0, 11'h000, 11'h300, 1'b0, 1'b0, 1'b1}, // R2 re-arm while armed
        {1'b0, 1'b1, 1'b0, 11'h7FF, 11'h7FF, 1'b1, 1'b0, 1'b0}, // R4 all-ones frame
        {1'b1, 1'b0, 1'b0, 11'h000, 11'h7FF, 1'b0, 1'b0, 1'b1}, // R3
        {1'b0, 1'b1, 1'b1, 11'h001, 11'h7FF, 1'b0, 1'b1, 1'b0}  // R5 keeps 0x7FF
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sof_pid_stb = 1'b0;
    logic        eop_stb = 1'b0;
    logic        tok_err = 1'b0;
    logic [10:0] frame_field = '0;
    logic [10:0] frame_num;
    logic        frame_ok;
    logic        frame_err;
    logic        sof_irq;
    logic [31:0] status_word;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sof_frame_tracker uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .sof_pid_stb (sof_pid_stb),
        .eop_stb     (eop_stb),
        .tok_err     (tok_err),
        .frame_field (frame_field),
        .frame_num   (frame_num),
        .frame_ok    (frame_ok),
        .frame_err   (frame_err),
        .sof_irq     (sof_irq),
        .status_word (status_word)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] word_of(input logic [10:0] f, input logic ok, input logic er);
        logic [31:0] w;
        w = '0;
        w[10:0] = f;
        w[16] = er;
        w[17] = ok;
        return w;
    endfunction

    task automatic check_all(input string req, input logic [10:0] f, input logic ok,
                             input logic er, input logic irq);
        check({req, " frame"}, 32'(frame_num), 32'(f));
        check({req, " ok"}, 32'(frame_ok), 32'(ok));
        check({req, " err"}, 32'(frame_err), 32'(er));
        check({req, " irq"}, 32'(sof_irq), 32'(irq));
        check({req, " R9 word"}, status_word, word_of(f, ok, er));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_all("R1 reset", 11'h000, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        // orphan eop right after reset
        @(negedge clk);
        eop_stb = 1'b1; frame_field = 11'h123;
        @(posedge clk); #1;
        check_all("R7 idle eop", 11'h000, 1'b0, 1'b0, 1'b0);
        // vector walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {sof_pid_stb, eop_stb, tok_err, frame_field} = VEC[i][27:14];
            @(posedge clk); #1;
            check_all($sformatf("vec%0d", i), VEC[i][13:3], VEC[i][2], VEC[i][1], VEC[i][0]);
        end
        // second eop after completed bad packet: ignored
        @(negedge clk);
        {sof_pid_stb, eop_stb, tok_err, frame_field} = {1'b0, 1'b1, 1'b0, 11'h222};
        @(posedge clk); #1;
        check_all("R7 repeat eop", 11'h7FF, 1'b0, 1'b1, 1'b0);
        // reset mid-run
        @(negedge clk);
        {sof_pid_stb, eop_stb, tok_err} = 3'b000;
        rst_n = 1'b0;
        #1;
        check_all("R1 mid reset", 11'h000, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule